// File: doc/BRIEF.md
# Conditional Flow Resolver

This block settles the control flow of an 8-bit RISC core's conditional relative branches and register-bit skips. For each accepted instruction it produces the next program counter, a flag that says whether the branch or skip took effect, and how many cycles the core spends on that instruction. Two branch forms are decoded: one branches when a chosen status flag is set, the other when that flag is clear. Two skip forms are also decoded: one skips when a chosen bit of a register operand is clear, the other when it is set. Every other instruction word falls through to PC + 1.

The core offers one request per accepted cycle. It supplies the current PC, the instruction word, the status byte, the register operand byte and a flag that says whether the instruction after this one is two words long. The result comes out one cycle later. The unit then stays busy for exactly as many cycles as the result says the instruction costs. While it is busy it ignores further requests.

The control is a three-state machine. `ST_IDLE` accepts a request (transition IDLE->DONE on `in_valid`). `ST_DONE` presents the result for one cycle and returns to IDLE when the cost is 1 (DONE->IDLE), otherwise it moves to the wait state (DONE->WAIT). `ST_WAIT` counts the extra cycles down. It stays while cycles remain (WAIT->WAIT) and goes to IDLE when the count is exhausted (WAIT->IDLE).

Top module: `cond_flow_unit`

## Requirements
- R1: After reset, out_valid, out_taken and busy are 0, out_pc is 0 and out_cycles is 0.
- R2: Instruction bits [15:10] = 111100 form the branch-when-set: it is taken when the status bit chosen by bits [2:0] is 1.
- R3: Instruction bits [15:10] = 111101 form the branch-when-clear: it is taken when the chosen status bit is 0.
- R4: Selector values 0..7 choose carry, zero, negative, overflow, signed, half-carry, transfer and interrupt-enable, in that order. With DERIVE_S = 1 (the default), selector 4 reads negative XOR overflow (status bits 2 and 3) and ignores status bit 4.
- R5: Bits [9:3] of a branch are a 7-bit two's-complement offset k (-64..+63). A taken branch yields PC + k + 1 and a not-taken branch yields PC + 1, both modulo 2^16.
- R6: A branch costs 1 cycle when not taken and 2 cycles when taken.
- R7: Bits [15:9] = 1111110 with bit 3 = 0 form skip-when-clear, and bits [15:9] = 1111111 with bit 3 = 0 form skip-when-set. Either form tests operand bit [2:0]. A skip yields PC + 2 at a cost of 2 cycles when in_next_two_word = 0, and PC + 3 at a cost of 3 cycles when it is 1. With no skip the result is PC + 1 at 1 cycle, and out_taken reports the skip.
- R8: Any other instruction word, including bit 3 = 1 in the skip space and 111110 in bits [15:10], yields PC + 1 with out_taken = 0 and out_cycles = 1.
- R9: out_valid is high for exactly one cycle, in the cycle after in_valid was accepted in the idle state.
- R10: busy is high for out_cycles consecutive cycles, starting in the out_valid cycle. A request made while busy is high is dropped and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, taken only when idle |
| in_pc | input | PC_W | PC of the instruction |
| in_instr | input | 16 | Instruction word |
| in_sreg | input | 8 | Status byte |
| in_operand | input | 8 | Register operand for the skip forms |
| in_next_two_word | input | 1 | Following instruction occupies two words |
| out_valid | output | 1 | Result strobe |
| out_pc | output | PC_W | Next program counter |
| out_taken | output | 1 | Branch taken or skip performed |
| out_cycles | output | 2 | Cycle cost of the instruction |
| busy | output | 1 | Unit occupied, requests dropped |

## Verification
A wrong decode or flag selection appears as a wrong out_pc or out_taken in the single out_valid cycle that follows the request, which is one clock after acceptance. A fault in the wait counter or in state sequencing does not change out_pc. It shows up as a busy window that is too short or too long, seen within at most three cycles, or as an extra or missing out_valid pulse when a request arrives during that window. The bench therefore measures the busy length after every request and keeps a count of result pulses against the requests it issued.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

    localparam int IW    = 16;
    localparam int OFF_W = 7;
    localparam int SEL_W = 3;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BR_SET,
        OP_BR_CLR,
        OP_SK_CLR,
        OP_SK_SET
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DONE,
        ST_WAIT
    } state_e;

endpackage

// File: rtl/cfu_decode.sv
module cfu_decode
    import cfu_pkg::*;
(
    input  logic [IW-1:0]    instr,
    output op_e              op,
    output logic [OFF_W-1:0] off,
    output logic [SEL_W-1:0] sel
);

    always_comb begin
        op  = OP_NONE;
        off = '0;
        sel = instr[SEL_W-1:0];
        if (instr[15:11] == 5'b11110) begin
            // conditional relative branch on a status flag
            op  = instr[10] ? OP_BR_CLR : OP_BR_SET;
            off = instr[9:3];
        end else if (instr[15:10] == 6'b111111 && !instr[3]) begin
            // skip on a register operand bit
            op  = instr[9] ? OP_SK_SET : OP_SK_CLR;
        end
    end

endmodule

// File: rtl/cfu_cond.sv
module cfu_cond
    import cfu_pkg::*;
#(
    parameter bit DERIVE_S = 1'b1
) (
    input  op_e              op,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       sreg,
    input  logic [7:0]       operand,
    output logic             hit
);

    logic [7:0] flags;

    generate
        if (DERIVE_S) begin : g_derived_s
            logic unused_sbit;
            assign unused_sbit = sreg[4];
            assign flags = {sreg[7:5], sreg[2] ^ sreg[3], sreg[3:0]};
        end else begin : g_stored_s
            assign flags = sreg;
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_BR_SET: hit =  flags[sel];
            OP_BR_CLR: hit = !flags[sel];
            OP_SK_CLR: hit = !operand[sel];
            OP_SK_SET: hit =  operand[sel];
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfu_target.sv
module cfu_target
    import cfu_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  op_e              op,
    input  logic [OFF_W-1:0] off,
    input  logic             hit,
    input  logic             two_word,
    output logic [PC_W-1:0]  next_pc,
    output logic [1:0]       cycles
);

    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] step;

    assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};

    always_comb begin
        step   = PC_W'(1);
        cycles = 2'd1;
        if (hit) begin
            unique case (op)
                OP_BR_SET, OP_BR_CLR: begin
                    step   = off_ext + PC_W'(1);
                    cycles = 2'd2;
                end
                OP_SK_CLR, OP_SK_SET: begin
                    step   = two_word ? PC_W'(3) : PC_W'(2);
                    cycles = two_word ? 2'd3 : 2'd2;
                end
                default: begin
                    step   = PC_W'(1);
                    cycles = 2'd1;
                end
            endcase
        end
    end

    assign next_pc = pc + step;

endmodule

// File: rtl/cond_flow_unit.sv
module cond_flow_unit
    import cfu_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter bit DERIVE_S = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [PC_W-1:0] in_pc,
    input  logic [IW-1:0]   in_instr,
    input  logic [7:0]      in_sreg,
    input  logic [7:0]      in_operand,
    input  logic            in_next_two_word,
    output logic            out_valid,
    output logic [PC_W-1:0] out_pc,
    output logic            out_taken,
    output logic [1:0]      out_cycles,
    output logic            busy
);

    op_e              dec_op;
    logic [OFF_W-1:0] dec_off;
    logic [SEL_W-1:0] dec_sel;
    logic             cond_hit;
    logic [PC_W-1:0]  calc_pc;
    logic [1:0]       calc_cycles;

    state_e     state, state_nx;
    logic [1:0] wait_cnt;
    logic       accept;

    cfu_decode u_decode (
        .instr (in_instr),
        .op    (dec_op),
        .off   (dec_off),
        .sel   (dec_sel)
    );

    cfu_cond #(.DERIVE_S(DERIVE_S)) u_cond (
        .op      (dec_op),
        .sel     (dec_sel),
        .sreg    (in_sreg),
        .operand (in_operand),
        .hit     (cond_hit)
    );

    cfu_target #(.PC_W(PC_W)) u_target (
        .pc       (in_pc),
        .op       (dec_op),
        .off      (dec_off),
        .hit      (cond_hit),
        .two_word (in_next_two_word),
        .next_pc  (calc_pc),
        .cycles   (calc_cycles)
    );

    assign accept = (state == ST_IDLE) && in_valid;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid) state_nx = ST_DONE;
            ST_DONE: state_nx = (out_cycles > 2'd1) ? ST_WAIT : ST_IDLE;
            ST_WAIT: if (wait_cnt == 2'd0) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= 2'd0;
        end else begin
            state <= state_nx;
            if (state == ST_DONE)
                wait_cnt <= out_cycles - 2'd2;
            else if (state == ST_WAIT && wait_cnt != 2'd0)
                wait_cnt <= wait_cnt - 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_pc     <= '0;
            out_taken  <= 1'b0;
            out_cycles <= 2'd0;
        end else if (accept) begin
            out_pc     <= calc_pc;
            out_taken  <= cond_hit;
            out_cycles <= calc_cycles;
        end
    end

    always_comb begin
        out_valid = (state == ST_DONE);
        busy      = (state != ST_IDLE);
    end

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R9
    AST_AFTER_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R9
    AST_FALLTHROUGH_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_taken) |-> (out_pc == $past(in_pc) + PC_W'(1))); // R5
    AST_TAKEN_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_taken) |-> (out_cycles >= 2'd2)); // R6
    AST_SKIP_DISTANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_taken && ($past(dec_op) == OP_SK_CLR || $past(dec_op) == OP_SK_SET))
        |-> (out_pc == $past(in_pc) + ($past(in_next_two_word) ? PC_W'(3) : PC_W'(2)))); // R7
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !out_valid); // R10

endmodule

// File: tb/test_cond_flow_unit.sv
module test_cond_flow_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_pc = '0;
    logic [15:0] in_instr = '0;
    logic [7:0]  in_sreg = '0;
    logic [7:0]  in_operand = '0;
    logic        in_next_two_word = 1'b0;
    logic        out_valid;
    logic [15:0] out_pc;
    logic        out_taken;
    logic [1:0]  out_cycles;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int issued = 0;
    int seen   = 0;

    logic [18:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    cond_flow_unit i_cond_flow_unit (
        .clk              (clk),
        .rst_n            (rst_n),
        .in_valid         (in_valid),
        .in_pc            (in_pc),
        .in_instr         (in_instr),
        .in_sreg          (in_sreg),
        .in_operand       (in_operand),
        .in_next_two_word (in_next_two_word),
        .out_valid        (out_valid),
        .out_pc           (out_pc),
        .out_taken        (out_taken),
        .out_cycles       (out_cycles),
        .busy             (busy)
    );

    function automatic logic [15:0] br(input bit when_clear, input int k, input int s);
        logic [6:0] kk = 7'(k);
        return {5'b11110, when_clear, kk, 3'(s)};
    endfunction

    function automatic logic [15:0] sk(input bit when_set, input int r, input int b);
        return {6'b111111, when_set, 5'(r), 1'b0, 3'(b)};
    endfunction

    // expected {pc, taken, cycles} from the requirements
    function automatic logic [18:0] model(input logic [15:0] pc, input logic [15:0] ins,
                                          input logic [7:0] sr, input logic [7:0] opd,
                                          input logic two);
        logic [7:0]  f = sr;
        logic        hit;
        logic [15:0] npc;
        logic [1:0]  cyc;
        f[4] = sr[2] ^ sr[3];
        npc = pc + 16'd1;
        cyc = 2'd1;
        hit = 1'b0;
        if (ins[15:10] == 6'b111100 || ins[15:10] == 6'b111101) begin
            hit = ins[10] ? !f[ins[2:0]] : f[ins[2:0]];
            if (hit) begin
                npc = pc + 16'd1 + {{9{ins[9]}}, ins[9:3]};
                cyc = 2'd2;
            end
        end else if (ins[15:10] == 6'b111111 && ins[3] == 1'b0) begin
            hit = ins[9] ? opd[ins[2:0]] : !opd[ins[2:0]];
            if (hit) begin
                npc = pc + (two ? 16'd3 : 16'd2);
                cyc = two ? 2'd3 : 2'd2;
            end
        end
        return {npc, hit, cyc};
    endfunction

    // monitor: pops and compares each result as it appears
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            seen++;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected result pc=%h exp=no result", out_pc);
            end else begin
                logic [18:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({out_pc, out_taken, out_cycles} !== e) begin
                    errors++;
                    $display("FAIL %s pc/taken/cycles act=%h/%b/%0d exp=%h/%b/%0d",
                             t, out_pc, out_taken, out_cycles, e[18:3], e[2], e[1:0]);
                end
            end
        end
    end

    task automatic issue(input logic [15:0] pc, input logic [15:0] ins, input logic [7:0] sr,
                         input logic [7:0] opd, input logic two, input string tag,
                         input bit poke = 1'b0);
        logic [18:0] e;
        int n;
        e = model(pc, ins, sr, opd, two);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        in_pc = pc; in_instr = ins; in_sreg = sr; in_operand = opd; in_next_two_word = two;
        in_valid = 1'b1;
        issued++;
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b1) begin
            errors++;
            $display("FAIL R9 out_valid act=%b exp=1", out_valid);
        end
        n = 0;
        while (busy && n < 8) begin
            n++;
            if (poke && n == 1) begin
                in_instr = br(1'b0, 5, 0);
                in_sreg  = 8'hFF;
                in_valid = 1'b1;
            end
            @(negedge clk);
            in_valid = 1'b0;
        end
        checks++;
        if (n != int'(e[1:0])) begin
            errors++;
            $display("FAIL R10 busy length act=%0d exp=%0d", n, e[1:0]);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || busy !== 1'b0 || out_taken !== 1'b0 ||
            out_pc !== 16'h0 || out_cycles !== 2'd0) begin
            errors++;
            $display("FAIL R1 reset act=%b%b%b %h %0d exp=000 0000 0",
                     out_valid, busy, out_taken, out_pc, out_cycles);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: each selector with only its own status bit set, then with all others set
        for (int s = 0; s < 8; s++) begin
            issue(16'h0100 + 16'(s), br(1'b0, 5, s), 8'(1 << s), 8'h00, 1'b0, "R2");
            issue(16'h0200 + 16'(s), br(1'b1, -3, s), 8'(1 << s), 8'h00, 1'b0, "R3");
            issue(16'h0300 + 16'(s), br(1'b1, 9, s), ~8'(1 << s), 8'h00, 1'b0, "R3");
            issue(16'h0400 + 16'(s), br(1'b0, 9, s), ~8'(1 << s), 8'h00, 1'b0, "R4");
        end
        // R4: signed flag follows N xor V, not the stored bit
        issue(16'h0500, br(1'b0, 4, 4), 8'h04, 8'h00, 1'b0, "R4");
        issue(16'h0510, br(1'b0, 4, 4), 8'h1C, 8'h00, 1'b0, "R4");
        issue(16'h0520, br(1'b1, 4, 4), 8'h18, 8'h00, 1'b0, "R4");

        // R5 R6: offset extremes and wrap-around
        issue(16'h1000, br(1'b0, 63, 1), 8'h02, 8'h00, 1'b0, "R5");
        issue(16'h1000, br(1'b0, -64, 1), 8'h02, 8'h00, 1'b0, "R5");
        issue(16'hFFF0, br(1'b0, 63, 0), 8'h01, 8'h00, 1'b0, "R5");
        issue(16'h0010, br(1'b1, -64, 0), 8'h00, 8'h00, 1'b0, "R5");
        issue(16'hFFFF, br(1'b0, 63, 0), 8'h00, 8'h00, 1'b0, "R6");
        issue(16'h2000, br(1'b0, -1, 7), 8'h80, 8'h00, 1'b0, "R6");

        // R7: skips with one- and two-word successors
        issue(16'h3000, sk(1'b0, 17, 1), 8'h00, 8'hA5, 1'b0, "R7");
        issue(16'h3000, sk(1'b0, 17, 1), 8'h00, 8'hA5, 1'b1, "R7");
        issue(16'h3000, sk(1'b0, 3, 0), 8'h00, 8'hA5, 1'b1, "R7");
        issue(16'h3100, sk(1'b1, 31, 7), 8'h00, 8'hA5, 1'b0, "R7");
        issue(16'h3100, sk(1'b1, 0, 6), 8'h00, 8'hA5, 1'b1, "R7");
        issue(16'hFFFE, sk(1'b1, 2, 2), 8'h00, 8'hA5, 1'b1, "R7");

        // R8: other words fall through
        issue(16'h4000, 16'h0000, 8'hFF, 8'hFF, 1'b1, "R8");
        issue(16'h4001, 16'hF807, 8'hFF, 8'hFF, 1'b1, "R8");
        issue(16'h4002, 16'hFC08, 8'h00, 8'h00, 1'b1, "R8");
        issue(16'hFFFF, 16'hE0FF, 8'hFF, 8'h00, 1'b0, "R8");

        // R10: request during the busy window is dropped
        issue(16'h5000, sk(1'b0, 1, 3), 8'h00, 8'h00, 1'b1, "R10", 1'b1);
        issue(16'h5100, br(1'b0, 2, 1), 8'h02, 8'h00, 1'b0, "R10", 1'b1);

        repeat (4) @(negedge clk);
        checks++;
        if (seen != issued || exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9 result count act=%0d exp=%0d", seen, issued);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule